// File: doc/BRIEF.md
# Camera Pixel Capture and 2:1 Downscaler

This block sits in the pixel-clock domain of a parallel image sensor and turns its byte stream into frame-buffer writes. Each RGB565 pixel arrives as two bytes on an 8-bit bus while a line-valid input is high. A frame-sync input is high between frames. The block pairs the bytes, cuts every colour channel down to its top four bits, and keeps only one pixel out of each 2x2 square of the sensor image. For each kept pixel it presents a 12-bit colour word and a linear buffer address on a valid-qualified output.

The sensor cannot be stalled, so the output stream has no ready input. A consumer has to accept every beat in the cycle that `out_valid` is high. Because of the pairing and decimation, valid beats are never adjacent, so a memory write port with one cycle of latency is enough. Two single-cycle pulses mark the frame boundaries for downstream stages.

Top module: `pcd_capture`

## Requirements
- R1: While `rst_n` is low and on the first sample after reset with idle inputs, `out_valid`, `out_pix`, `out_addr`, `frame_start` and `frame_end` are all zero.
- R2: While line-valid is high and frame-sync is low, bytes alternate between first and second of a pair, starting with a first byte. The first byte is pixel bits 15:8 and the second is bits 7:0. A write can only follow a second byte. Whenever line-valid is low, the next byte is treated as a first byte again.
- R3: The written colour is {R[3:0], G[3:0], B[3:0]}, with R = pixel[15:12], G = pixel[10:7] and B = pixel[4:1] of the 16-bit pixel.
- R4: The column index counts completed pixels within the line and starts at 0 each line. Only even column indices are written.
- R5: The row index counts line-valid high-to-low transitions since frame-sync was last high. Only even row indices are written.
- R6: The address of a written pixel is (row/2)*(IN_W/2) + col/2.
- R7: Pixels with column index at least IN_W, or row index at least IN_H, are not written.
- R8: While frame-sync is high, no pixel is written and the row index returns to 0.
- R9: `frame_end` is high for exactly the one cycle after the edge on which frame-sync is first sampled high. `frame_start` is high for the one cycle after the edge on which it is first sampled low again.
- R10: `out_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Camera pixel clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cam_data | input | 8 | Sensor byte bus |
| cam_line_valid | input | 1 | High while the bytes of a line are on the bus |
| cam_frame_sync | input | 1 | High during the gap between frames |
| out_valid | output | 1 | A kept pixel is on `out_pix`/`out_addr` this cycle |
| out_pix | output | 12 | RGB444 colour of the kept pixel |
| out_addr | output | ADDR_W | Linear frame-buffer address of the kept pixel |
| frame_start | output | 1 | One-cycle pulse after frame-sync falls |
| frame_end | output | 1 | One-cycle pulse after frame-sync rises |

## Verification
Whole frames of nominal size show whether row and column decimation keep the even/even pixel, and whether the address walks the output buffer in raster order. Lines with an odd byte count show whether the byte phase resynchronises at the next line, so that a broken phase is separated from a broken colour mapping. Lines and frames longer than nominal, and a frame-sync that rises in the middle of a line, exercise the bounds clip and the row reset. Random bytes in random frame shapes exercise every bit of the channel truncation.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef struct packed {
    logic [3:0] r;
    logic [3:0] g;
    logic [3:0] b;
  } rgb444_t;

  // Keep the top four bits of each RGB565 channel.
  function automatic rgb444_t trunc565(input logic [15:0] p);
    rgb444_t c;
    c.r = p[15:12];
    c.g = p[10:7];
    c.b = p[4:1];
    return c;
  endfunction
endpackage

// File: rtl/pcd_byte_pair.sv
module pcd_byte_pair (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_act,
  input  logic [7:0]  data,
  output logic        pair_done,
  output logic [15:0] pix16
);
  logic       second_q;
  logic [7:0] hi_q;

  assign pair_done = line_act & second_q;
  assign pix16     = {hi_q, data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second_q <= 1'b0;
      hi_q     <= '0;
    end else begin
      second_q <= line_act ? ~second_q : 1'b0;
      if (line_act && !second_q) hi_q <= data;
    end
  end
endmodule

// File: rtl/pcd_position.sv
module pcd_position #(
  parameter int IN_W = 640,
  parameter int IN_H = 480,
  localparam int CW = $clog2(IN_W + 1),
  localparam int RW = $clog2(IN_H + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_act,
  input  logic          fsync,
  input  logic          pair_done,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic          in_bounds,
  output logic          fstart,
  output logic          fend
);
  localparam logic [CW-1:0] COL_LIM = CW'(IN_W);
  localparam logic [RW-1:0] ROW_LIM = RW'(IN_H);

  logic act_d, fs_d;

  assign in_bounds = (col < COL_LIM) && (row < ROW_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col    <= '0;
      row    <= '0;
      act_d  <= 1'b0;
      fs_d   <= 1'b0;
      fstart <= 1'b0;
      fend   <= 1'b0;
    end else begin
      if (!line_act)                       col <= '0;
      else if (pair_done && col != COL_LIM) col <= col + 1'b1;

      if (fsync)                                       row <= '0;
      else if (act_d && !line_act && row != ROW_LIM)   row <= row + 1'b1;

      act_d  <= line_act;
      fs_d   <= fsync;
      fstart <= fs_d & ~fsync;
      fend   <= fsync & ~fs_d;
    end
  end
endmodule

// File: rtl/pcd_capture.sv
module pcd_capture #(
  parameter int IN_W = 640,
  parameter int IN_H = 480,
  localparam int OUT_W  = IN_W / 2,
  localparam int OUT_H  = IN_H / 2,
  localparam int ADDR_W = $clog2(OUT_W * OUT_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cam_data,
  input  logic              cam_line_valid,
  input  logic              cam_frame_sync,
  output logic              out_valid,
  output logic [11:0]       out_pix,
  output logic [ADDR_W-1:0] out_addr,
  output logic              frame_start,
  output logic              frame_end
);
  import pcd_pkg::*;

  localparam int CW = $clog2(IN_W + 1);
  localparam int RW = $clog2(IN_H + 1);

  logic          line_act, pair_done, in_bounds, keep;
  logic [15:0]   pix16;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [ADDR_W-1:0] addr_nx;

  assign line_act = cam_line_valid & ~cam_frame_sync;

  pcd_byte_pair u_pair (
    .clk(clk), .rst_n(rst_n), .line_act(line_act), .data(cam_data),
    .pair_done(pair_done), .pix16(pix16)
  );

  pcd_position #(.IN_W(IN_W), .IN_H(IN_H)) u_pos (
    .clk(clk), .rst_n(rst_n), .line_act(line_act), .fsync(cam_frame_sync),
    .pair_done(pair_done), .col(col), .row(row), .in_bounds(in_bounds),
    .fstart(frame_start), .fend(frame_end)
  );

  assign keep    = pair_done & in_bounds & ~col[0] & ~row[0];
  assign addr_nx = ADDR_W'(row >> 1) * ADDR_W'(OUT_W) + ADDR_W'(col >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_addr  <= '0;
    end else begin
      out_valid <= keep;
      if (keep) begin
        out_pix  <= trunc565(pix16);
        out_addr <= addr_nx;
      end
    end
  end
endmodule

// File: rtl/pcd_capture_chk.sv
module pcd_capture_chk #(
  parameter int IN_W = 640,
  parameter int IN_H = 480,
  localparam int ADDR_W = $clog2((IN_W / 2) * (IN_H / 2))
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cam_line_valid,
  input logic              cam_frame_sync,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              frame_start,
  input logic              frame_end
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'((IN_W / 2) * (IN_H / 2) - 1);

  AST_WRITE_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(cam_line_valid) && !$past(cam_frame_sync))); // R8
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr <= LAST_ADDR)); // R6
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R10
  AST_PULSES_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && frame_end)); // R9
  AST_END_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> $past(cam_frame_sync)); // R9
  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !$past(cam_frame_sync)); // R9
endmodule

bind pcd_capture pcd_capture_chk #(.IN_W(IN_W), .IN_H(IN_H)) u_chk (
  .clk(clk), .rst_n(rst_n), .cam_line_valid(cam_line_valid),
  .cam_frame_sync(cam_frame_sync), .out_valid(out_valid), .out_addr(out_addr),
  .frame_start(frame_start), .frame_end(frame_end)
);

// File: tb/pcd_capture_bench.sv
`timescale 1ns/1ps
module pcd_capture_bench;
  localparam int IN_W = 8;
  localparam int IN_H = 6;
  localparam int OW = IN_W / 2;
  localparam int OH = IN_H / 2;
  localparam int AW = $clog2(OW * OH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    cam_data = '0;
  logic          cam_line_valid = 1'b0;
  logic          cam_frame_sync = 1'b0;
  logic          out_valid, frame_start, frame_end;
  logic [11:0]   out_pix;
  logic [AW-1:0] out_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  bit       m_second = 0;
  int       m_hi = 0;
  int       m_col = 0;
  int       m_row = 0;
  bit       m_act_d = 0;
  bit       m_fs_d = 0;
  bit       prev_valid = 0;

  always #2 clk = ~clk;

  pcd_capture #(.IN_W(IN_W), .IN_H(IN_H)) u_pcd_capture (
    .clk(clk), .rst_n(rst_n), .cam_data(cam_data),
    .cam_line_valid(cam_line_valid), .cam_frame_sync(cam_frame_sync),
    .out_valid(out_valid), .out_pix(out_pix), .out_addr(out_addr),
    .frame_start(frame_start), .frame_end(frame_end)
  );

  function automatic int exp_color(int hi, int lo);
    int r, g, b;
    r = (hi >> 4) & 15;
    g = ((hi & 7) << 1) | ((lo >> 7) & 1);
    b = (lo >> 1) & 15;
    return (r << 8) | (g << 4) | b;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one byte slot, then compare outputs after the edge.
  task automatic step(input int d, input bit lv, input bit fs, input string tag);
    bit act, pair, keep, efs, efe;
    int epix, eaddr;
    @(negedge clk);
    cam_data = 8'(d); cam_line_valid = lv; cam_frame_sync = fs;
    act  = lv && !fs;
    pair = act && m_second;
    keep = pair && (m_col % 2 == 0) && (m_row % 2 == 0) && m_col < IN_W && m_row < IN_H;
    epix  = exp_color(m_hi, d & 255);
    eaddr = (m_row / 2) * OW + m_col / 2;
    efs = !fs && m_fs_d;
    efe = fs && !m_fs_d;
    if (act && !m_second) m_hi = d & 255;
    m_second = act ? !m_second : 0;
    if (pair && m_col < IN_W) m_col++;
    if (!act) m_col = 0;
    if (fs) m_row = 0;
    else if (m_act_d && !act && m_row < IN_H) m_row++;
    m_act_d = act;
    m_fs_d = fs;
    @(posedge clk); #1;
    check(tag, int'(out_valid), int'(keep));
    if (keep && out_valid) begin
      check("R3 pixel", int'(out_pix), epix);
      check("R6 address", int'(out_addr), eaddr);
    end
    check("R9 frame_start", int'(frame_start), int'(efs));
    check("R9 frame_end", int'(frame_end), int'(efe));
    if (prev_valid && out_valid) check("R10 adjacent valid", 1, 0);
    prev_valid = out_valid;
  endtask

  task automatic line(input int nbytes, input string tag);
    for (int i = 0; i < nbytes; i++) step(int'($urandom % 256), 1, 0, tag);
    step(0, 0, 0, tag);
    step(0, 0, 0, tag);
  endtask

  task automatic vblank(input string tag);
    for (int i = 0; i < 3; i++) step(0, 0, 1, tag);
    step(0, 0, 0, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_pix", int'(out_pix), 0);
    check("R1 out_addr", int'(out_addr), 0);
    check("R1 pulses", int'(frame_start) + int'(frame_end), 0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, "R1 idle");

    // R4 R5: nominal frame, raster order of kept pixels
    vblank("R9 vblank");
    for (int l = 0; l < IN_H; l++) line(2 * IN_W, "R4 nominal");

    // R2: odd byte count, next line must restart on a first byte
    vblank("R9 vblank");
    line(2 * IN_W - 3, "R2 odd line");
    step(8'hF0, 1, 0, "R2 first byte");
    step(8'h81, 1, 0, "R2 second byte");
    step(0, 0, 0, "R2 gap");
    step(0, 0, 0, "R2 gap");
    for (int l = 1; l < IN_H; l++) line(2 * IN_W + 1, "R2 odd line");

    // R7: overlong lines and extra rows
    vblank("R9 vblank");
    for (int l = 0; l < IN_H + 3; l++) line(2 * IN_W + 6, "R7 clip");

    // R8: frame-sync rises mid-line with line-valid still high
    vblank("R9 vblank");
    line(2 * IN_W, "R5 row0");
    line(2 * IN_W, "R5 row1");
    for (int i = 0; i < 3; i++) step(int'($urandom % 256), 1, 0, "R8 pre");
    for (int i = 0; i < 6; i++) step(int'($urandom % 256), 1, 1, "R8 sync high");
    step(0, 0, 0, "R8 end");
    for (int l = 0; l < IN_H; l++) line(2 * IN_W, "R5 after reset row");

    // random frames
    for (int f = 0; f < 40; f++) begin
      int nl;
      vblank("R9 vblank");
      nl = IN_H - 1 + int'($urandom % 4);
      for (int l = 0; l < nl; l++) begin
        int nb;
        nb = 2 * (IN_W - 1) + int'($urandom % 7);
        line(nb, "R4 random");
        if ($urandom % 3 == 0) step(0, 0, 0, "R5 gap");
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule